// File: doc/BRIEF.md
# TDM Per-Channel Connection Store and Output Stage

This block holds one 16-bit control word per output channel of a time-division-multiplexed switch and turns each word into the action for that channel's timeslot. A host port writes and reads the words. The host reaches this store only when its 3-bit memory-select field matches the code the instance is built with: 000 for the local-side store and 001 for the backplane-side store.

For each timeslot the slot sequencer presents the channel number one cycle ahead of the slot. The stage reads the word and then does one of three things. It can issue a read address (input side, stream, channel) to the switch data memory. It can emit the message byte held in the word. It can drive the channel to high impedance. How the source address is split depends on the bit rate of the chosen input side. A one-shot fill writes a preset word into every location, one per clock, so that the store can be set up quickly after power-up.

Top module: `tdm_cm_out`

## Requirements
- R1: While and just after reset, `bp_busy`, `out_valid`, `out_oe`, `dm_rd_en` and `host_rvalid` are all 0.
- R2: A host write with `host_sel` equal to `SEL_CODE` (default 000) stores `host_wdata` at `host_addr`. A host read with a matching select sets `host_rvalid` in the next cycle, with `host_rdata` equal to the word stored before that read's edge.
- R3: A host write or read whose `host_sel` differs from `SEL_CODE` has no effect: the stored word is unchanged and `host_rvalid` stays 0.
- R4: Word bit 15 selects the source side (1 = backplane, uses `bp_rate`; 0 = local, uses `loc_rate`). Rate codes are 0=2, 1=4, 2=8, 3=16 and 4=32 Mb/s. At codes 0 to 3, a connection word (bit 14 = 0, bit 13 = 0) gives stream = bits [12:8] and channel = bits [7:0]. `dm_rd_en` is high in the cycle after the lookup, with `dm_side` equal to bit 15.
- R5: At code 4 on the backplane side, stream = bits [12:9] and channel = bits [8:0]. Every channel 0 to 511 is legal.
- R6: A connection word is illegal in three cases: its channel exceeds the rate's limit (31, 63, 127 or 255 for codes 0 to 3); code 4 is chosen for the local side; or the rate code is 5 to 7. An illegal word issues no data-memory read and gives `out_oe` = 0.
- R7: A message word (bit 14 = 1, bit 13 = 0) issues no data-memory read. Two cycles after the lookup it gives `out_oe` = 1 and `out_byte` = bits [7:0]. Bits [12:8] are ignored.
- R8: Bit 13 = 1 forces the slot to high impedance whatever the other bits hold: no data-memory read, `out_oe` = 0 and `out_byte` = 0.
- R9: `out_valid` rises exactly two cycles after each lookup. For a legal connection, `out_oe` = 1 and `out_byte` is the `dm_rdata` returned one cycle after `dm_rd_en`.
- R10: A `bp_start` pulse while idle raises `bp_busy` from the next cycle for exactly DEPTH cycles. During that time every location is written with the `bp_value` captured at the start. `bp_busy` then clears by itself.
- R11: Host writes are dropped while `bp_busy` is high. After the fill, such a location still holds the fill word.
- R12: When a host write and a lookup hit the same address in the same cycle, the lookup acts on the old word. The next lookup of that address acts on the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 3 | Host memory-select field |
| host_addr | input | ADDR_W | Host word address |
| host_we | input | 1 | Host write strobe |
| host_wdata | input | 16 | Host write word |
| host_re | input | 1 | Host read strobe |
| host_rdata | output | 16 | Host read word |
| host_rvalid | output | 1 | Host read word valid |
| bp_start | input | 1 | Start fill pulse |
| bp_value | input | 16 | Fill word |
| bp_busy | output | 1 | Fill in progress |
| loc_rate | input | 3 | Local-side source rate code |
| bp_rate | input | 3 | Backplane-side source rate code |
| slot_req | input | 1 | Lookup for the next timeslot |
| slot_chan | input | ADDR_W | Channel of the next timeslot |
| dm_rd_en | output | 1 | Data-memory read strobe |
| dm_side | output | 1 | Data-memory side (1 = backplane) |
| dm_stream | output | 5 | Data-memory source stream |
| dm_chan | output | 9 | Data-memory source channel |
| dm_rdata | input | 8 | Data-memory read byte (one cycle latency) |
| out_valid | output | 1 | Timeslot result valid |
| out_oe | output | 1 | Timeslot output enable |
| out_byte | output | 8 | Timeslot output byte |

## Verification
The main function is tried with fixed words that cover every slot action. These are a local connection at the edge of its channel limit, a backplane connection at 32 Mb/s, over-limit channels and 32 Mb/s on the local side, message words with junk in bits [12:8], and high-impedance connection and message words. Together they separate the two address splits from each other and the three slot actions from one another. The same words are looked up again under other rate pairs, so that the channel limits and the side-dependent rate choice are exercised. A pseudo-random mix of host writes, reads with both select codes, and back-to-back lookups then checks the read-before-write order and the two-cycle alignment. A second fill carries lookups that run during it.

// File: rtl/tdm_cm_pkg.sv
`timescale 1ns/1ps
package tdm_cm_pkg;
  localparam int WORD_W   = 16;
  localparam int SIDE_POS = 15;
  localparam int MSG_POS  = 14;
  localparam int HIZ_POS  = 13;

  typedef enum logic [2:0] {
    RATE_2M  = 3'd0,
    RATE_4M  = 3'd1,
    RATE_8M  = 3'd2,
    RATE_16M = 3'd3,
    RATE_32M = 3'd4
  } rate_e;

  typedef struct packed {
    logic       rd;
    logic       side;
    logic [4:0] stream;
    logic [8:0] chan;
    logic       oe;
    logic       msg;
    logic [7:0] msg_byte;
  } slot_act_t;

  // highest legal source channel for a rate below 32 Mb/s
  function automatic logic [8:0] chan_limit(rate_e r);
    case (r)
      RATE_2M:  return 9'd31;
      RATE_4M:  return 9'd63;
      RATE_8M:  return 9'd127;
      RATE_16M: return 9'd255;
      default:  return 9'd511;
    endcase
  endfunction

  function automatic rate_e pick_rate(logic side, logic [2:0] loc, logic [2:0] bp);
    return rate_e'(side ? bp : loc);
  endfunction

  function automatic slot_act_t decode_word(logic [WORD_W-1:0] w, rate_e r);
    slot_act_t a;
    logic      legal;
    logic      low_rate;
    a.side     = w[SIDE_POS];
    a.msg      = w[MSG_POS];
    a.msg_byte = w[7:0];
    low_rate   = (r == RATE_2M) || (r == RATE_4M) || (r == RATE_8M) || (r == RATE_16M);
    if (r == RATE_32M) begin
      a.stream = {1'b0, w[12:9]};
      a.chan   = w[8:0];
      legal    = w[SIDE_POS];
    end else begin
      a.stream = w[12:8];
      a.chan   = {1'b0, w[7:0]};
      legal    = low_rate && ({1'b0, w[7:0]} <= chan_limit(r));
    end
    a.oe = !w[HIZ_POS] && (w[MSG_POS] || legal);
    a.rd = !w[HIZ_POS] && !w[MSG_POS] && legal;
    return a;
  endfunction
endpackage

// File: rtl/tdm_cm_fill.sv
`timescale 1ns/1ps
module tdm_cm_fill #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic [ADDR_W-1:0] fill_addr
);
  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

  logic              busy_q;
  logic [ADDR_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) busy_q <= 1'b0;
    end
  end

  assign busy      = busy_q;
  assign fill_addr = cnt_q;
endmodule

// File: rtl/tdm_cm_store.sv
`timescale 1ns/1ps
module tdm_cm_store #(
  parameter int ADDR_W = 11,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              lk_re,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_vld,
  output logic [WORD_W-1:0] lk_word,
  input  logic              h_re,
  input  logic [ADDR_W-1:0] h_addr,
  output logic              h_vld,
  output logic [WORD_W-1:0] h_word
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] lk_q, h_q;
  logic              lk_v_q, h_v_q;

  // both reads see the word as it was before this edge's write
  always_ff @(posedge clk) begin
    if (lk_re) lk_q <= mem[lk_addr];
    if (h_re)  h_q  <= mem[h_addr];
    if (we)    mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_v_q <= 1'b0;
      h_v_q  <= 1'b0;
    end else begin
      lk_v_q <= lk_re;
      h_v_q  <= h_re;
    end
  end

  assign lk_vld  = lk_v_q;
  assign lk_word = lk_q;
  assign h_vld   = h_v_q;
  assign h_word  = h_q;
endmodule

// File: rtl/tdm_cm_slot.sv
`timescale 1ns/1ps
module tdm_cm_slot
  import tdm_cm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_vld,
  input  logic [WORD_W-1:0] lk_word,
  input  logic [2:0]        loc_rate,
  input  logic [2:0]        bp_rate,
  input  logic [7:0]        dm_rdata,
  output logic              dm_rd_en,
  output logic              dm_side,
  output logic [4:0]        dm_stream,
  output logic [8:0]        dm_chan,
  output logic              out_valid,
  output logic              out_oe,
  output logic [7:0]        out_byte
);
  rate_e     cur_rate;
  slot_act_t act;

  always_comb begin
    cur_rate = pick_rate(lk_word[SIDE_POS], loc_rate, bp_rate);
    act      = decode_word(lk_word, cur_rate);
  end

  assign dm_rd_en  = lk_vld & act.rd;
  assign dm_side   = act.side;
  assign dm_stream = act.stream;
  assign dm_chan   = act.chan;

  logic       v_q, oe_q, msg_q;
  logic [7:0] byte_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q    <= 1'b0;
      oe_q   <= 1'b0;
      msg_q  <= 1'b0;
      byte_q <= '0;
    end else begin
      v_q  <= lk_vld;
      oe_q <= lk_vld & act.oe;
      if (lk_vld) begin
        msg_q  <= act.msg;
        byte_q <= act.msg_byte;
      end
    end
  end

  assign out_valid = v_q;
  assign out_oe    = oe_q;
  assign out_byte  = !oe_q ? 8'h00 : (msg_q ? byte_q : dm_rdata);
endmodule

// File: rtl/tdm_cm_out.sv
`timescale 1ns/1ps
module tdm_cm_out
  import tdm_cm_pkg::*;
#(
  parameter int         ADDR_W   = 11,
  parameter logic [2:0] SEL_CODE = 3'b000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        host_sel,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_we,
  input  logic [15:0]       host_wdata,
  input  logic              host_re,
  output logic [15:0]       host_rdata,
  output logic              host_rvalid,
  input  logic              bp_start,
  input  logic [15:0]       bp_value,
  output logic              bp_busy,
  input  logic [2:0]        loc_rate,
  input  logic [2:0]        bp_rate,
  input  logic              slot_req,
  input  logic [ADDR_W-1:0] slot_chan,
  output logic              dm_rd_en,
  output logic              dm_side,
  output logic [4:0]        dm_stream,
  output logic [8:0]        dm_chan,
  input  logic [7:0]        dm_rdata,
  output logic              out_valid,
  output logic              out_oe,
  output logic [7:0]        out_byte
);
  // named events for the checker
  logic              sel_hit;
  logic              host_wr_ok;
  logic              host_rd_ok;
  logic              store_we;
  logic [ADDR_W-1:0] store_waddr;
  logic [WORD_W-1:0] store_wdata;
  logic [ADDR_W-1:0] fill_addr;
  logic [WORD_W-1:0] fill_val;
  logic              lk_vld;
  logic [WORD_W-1:0] lk_word;
  logic              lk_hiz;
  logic              lk_msg_mode;
  logic [7:0]        lk_msg_byte;

  assign sel_hit    = (host_sel == SEL_CODE);
  assign host_wr_ok = host_we & sel_hit & ~bp_busy;
  assign host_rd_ok = host_re & sel_hit;

  always_ff @(posedge clk) begin
    if (!rst_n)                    fill_val <= '0;
    else if (bp_start && !bp_busy) fill_val <= bp_value;
  end

  tdm_cm_fill #(.ADDR_W(ADDR_W)) fill_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (bp_start),
    .busy      (bp_busy),
    .fill_addr (fill_addr)
  );

  assign store_we    = bp_busy | host_wr_ok;
  assign store_waddr = bp_busy ? fill_addr : host_addr;
  assign store_wdata = bp_busy ? fill_val  : host_wdata;

  tdm_cm_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) store_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (store_we),
    .waddr   (store_waddr),
    .wdata   (store_wdata),
    .lk_re   (slot_req),
    .lk_addr (slot_chan),
    .lk_vld  (lk_vld),
    .lk_word (lk_word),
    .h_re    (host_rd_ok),
    .h_addr  (host_addr),
    .h_vld   (host_rvalid),
    .h_word  (host_rdata)
  );

  assign lk_hiz      = lk_word[HIZ_POS];
  assign lk_msg_mode = lk_word[MSG_POS];
  assign lk_msg_byte = lk_word[7:0];

  tdm_cm_slot slot_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_vld    (lk_vld),
    .lk_word   (lk_word),
    .loc_rate  (loc_rate),
    .bp_rate   (bp_rate),
    .dm_rdata  (dm_rdata),
    .dm_rd_en  (dm_rd_en),
    .dm_side   (dm_side),
    .dm_stream (dm_stream),
    .dm_chan   (dm_chan),
    .out_valid (out_valid),
    .out_oe    (out_oe),
    .out_byte  (out_byte)
  );
endmodule

// File: rtl/tdm_cm_out_chk.sv
`timescale 1ns/1ps
module tdm_cm_out_chk #(
  parameter int         ADDR_W   = 11,
  parameter logic [2:0] SEL_CODE = 3'b000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bp_start,
  input logic              bp_busy,
  input logic [ADDR_W-1:0] fill_addr,
  input logic              store_we,
  input logic [15:0]       store_wdata,
  input logic [15:0]       fill_val,
  input logic [2:0]        host_sel,
  input logic              host_re,
  input logic              host_rvalid,
  input logic              lk_vld,
  input logic              lk_hiz,
  input logic              lk_msg_mode,
  input logic [7:0]        lk_msg_byte,
  input logic              dm_rd_en,
  input logic              dm_side,
  input logic [2:0]        loc_rate,
  input logic              out_valid,
  input logic              out_oe,
  input logic [7:0]        out_byte
);
  // R10
  fill_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bp_busy) |-> $past(bp_start));

  // R10
  fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_busy && $past(bp_busy)) |-> fill_addr == ADDR_W'($past(fill_addr) + 1'b1));

  // R11
  fill_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_busy && store_we) |-> store_wdata == fill_val);

  // R2
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rvalid |-> ($past(host_re) && $past(host_sel) == SEL_CODE));

  // R3
  rd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_re && host_sel != SEL_CODE) |=> !host_rvalid);

  // R7
  msg_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_vld && lk_msg_mode && !lk_hiz) |=> (out_oe && out_byte == $past(lk_msg_byte)));

  // R8
  hiz_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_vld && lk_hiz) |=> (out_valid && !out_oe && out_byte == 8'h00));

  // R6
  loc_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dm_rd_en && !dm_side) |-> loc_rate != 3'd4);

  // R9
  out_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(lk_vld));
endmodule

bind tdm_cm_out tdm_cm_out_chk #(.ADDR_W(ADDR_W), .SEL_CODE(SEL_CODE)) chk_i (.*);

// File: tb/tdm_cm_out_tb_top.sv
`timescale 1ns/1ps
module tdm_cm_out_tb_top;
  localparam int ADDR_W = 11;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [2:0]        host_sel = '0;
  logic [ADDR_W-1:0] host_addr = '0;
  logic              host_we = 1'b0;
  logic [15:0]       host_wdata = '0;
  logic              host_re = 1'b0;
  logic [15:0]       host_rdata;
  logic              host_rvalid;
  logic              bp_start = 1'b0;
  logic [15:0]       bp_value = '0;
  logic              bp_busy;
  logic [2:0]        loc_rate = 3'd2;
  logic [2:0]        bp_rate = 3'd4;
  logic              slot_req = 1'b0;
  logic [ADDR_W-1:0] slot_chan = '0;
  logic              dm_rd_en, dm_side;
  logic [4:0]        dm_stream;
  logic [8:0]        dm_chan;
  logic [7:0]        dm_rdata = '0;
  logic              out_valid, out_oe;
  logic [7:0]        out_byte;

  always #4 clk = ~clk;

  tdm_cm_out #(.ADDR_W(ADDR_W), .SEL_CODE(3'b000)) dut_i (.*);

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  function automatic int dm_val(int side, int stream, int chan);
    return (side * 37 + stream * 11 + chan * 3) & 255;
  endfunction

  // data memory: one-cycle read port
  always @(posedge clk)
    if (dm_rd_en) dm_rdata <= 8'(dm_val(int'(dm_side), int'(dm_stream), int'(dm_chan)));

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int mem_m [DEPTH];
  int m_busy = 0, m_cnt = 0, m_fill = 0;
  int s1_v = 0, s1_rd = 0, s1_side = 0, s1_stream = 0, s1_chan = 0, s1_oe = 0, s1_msg = 0, s1_byte = 0;
  string s1_tag = "R4";
  int s2_v = 0, s2_oe = 0, s2_byte = 0;
  string s2_tag = "R9";
  int hr_v = 0, hr_data = 0, hr_selbad = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; s1_v = 0; s1_rd = 0; s1_oe = 0; s2_v = 0; s2_oe = 0; hr_v = 0; hr_selbad = 0;
    end else begin
      int w, rate, legal;
      s2_v = s1_v;
      s2_oe = s1_oe;
      s2_byte = !s1_oe ? 0 : (s1_msg ? s1_byte : dm_val(s1_side, s1_stream, s1_chan));
      s2_tag = (s1_tag == "R4" || s1_tag == "R5") ? "R9" : s1_tag;
      s1_v = slot_req;
      if (slot_req) begin
        w = mem_m[slot_chan];
        s1_side = (w >> 15) & 1;
        s1_msg = (w >> 14) & 1;
        rate = s1_side ? int'(bp_rate) : int'(loc_rate);
        if (rate == 4) begin
          s1_stream = (w >> 9) & 15; s1_chan = w & 511; legal = s1_side;
        end else if (rate < 4) begin
          s1_stream = (w >> 8) & 31; s1_chan = w & 255; legal = (s1_chan < (32 << rate)) ? 1 : 0;
        end else begin
          s1_stream = (w >> 8) & 31; s1_chan = w & 255; legal = 0;
        end
        s1_byte = w & 255;
        s1_rd = (((w >> 13) & 1) == 0 && s1_msg == 0 && legal != 0) ? 1 : 0;
        s1_oe = (((w >> 13) & 1) == 0 && (s1_msg != 0 || legal != 0)) ? 1 : 0;
        s1_tag = ((w >> 13) & 1) != 0 ? "R8" : s1_msg != 0 ? "R7" : legal == 0 ? "R6" : rate == 4 ? "R5" : "R4";
      end else begin
        s1_rd = 0; s1_oe = 0;
      end
      hr_selbad = (host_re && host_sel != 3'b000) ? 1 : 0;
      hr_v = (host_re && host_sel == 3'b000) ? 1 : 0;
      if (hr_v != 0) hr_data = mem_m[host_addr];
      if (m_busy != 0) begin
        mem_m[m_cnt] = m_fill;
        m_cnt++;
        if (m_cnt == DEPTH) m_busy = 0;
      end else begin
        if (host_we && host_sel == 3'b000) mem_m[host_addr] = int'(host_wdata);
        if (bp_start) begin m_busy = 1; m_cnt = 0; m_fill = int'(bp_value); end
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(int'(bp_busy) == m_busy, "R10", "bp_busy", int'(bp_busy), m_busy);
      chk(int'(dm_rd_en) == (s1_v & s1_rd), s1_tag, "dm_rd_en", int'(dm_rd_en), s1_v & s1_rd);
      if ((s1_v & s1_rd) != 0) begin
        chk(int'(dm_side) == s1_side, s1_tag, "dm_side", int'(dm_side), s1_side);
        chk(int'(dm_stream) == s1_stream, s1_tag, "dm_stream", int'(dm_stream), s1_stream);
        chk(int'(dm_chan) == s1_chan, s1_tag, "dm_chan", int'(dm_chan), s1_chan);
      end
      chk(int'(out_valid) == s2_v, "R9", "out_valid", int'(out_valid), s2_v);
      if (s2_v != 0) begin
        chk(int'(out_oe) == s2_oe, s2_tag, "out_oe", int'(out_oe), s2_oe);
        chk(int'(out_byte) == s2_byte, s2_tag, "out_byte", int'(out_byte), s2_byte);
      end
      chk(int'(host_rvalid) == hr_v, hr_selbad != 0 ? "R3" : "R2", "host_rvalid", int'(host_rvalid), hr_v);
      if (hr_v != 0) chk(int'(host_rdata) == hr_data, "R2", "host_rdata", int'(host_rdata), hr_data);
    end
  end

  // ---------------- stimulus ----------------
  task automatic hwrite(input int a, input int d, input int sel);
    host_we = 1'b1; host_addr = ADDR_W'(a); host_wdata = 16'(d); host_sel = 3'(sel);
    @(negedge clk);
    host_we = 1'b0; host_sel = 3'b000;
  endtask

  task automatic hread(input int a, input int sel);
    host_re = 1'b1; host_addr = ADDR_W'(a); host_sel = 3'(sel);
    @(negedge clk);
    host_re = 1'b0; host_sel = 3'b000;
  endtask

  task automatic look(input int ch);
    slot_req = 1'b1; slot_chan = ADDR_W'(ch);
    @(negedge clk);
    slot_req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    int seed;
    idle(3);
    // R1: outputs quiet during reset
    chk(bp_busy == 1'b0, "R1", "bp_busy", int'(bp_busy), 0);
    chk(out_valid == 1'b0 && out_oe == 1'b0, "R1", "out_valid/oe", int'({out_valid, out_oe}), 0);
    chk(dm_rd_en == 1'b0, "R1", "dm_rd_en", int'(dm_rd_en), 0);
    chk(host_rvalid == 1'b0, "R1", "host_rvalid", int'(host_rvalid), 0);
    rst_n = 1'b1;
    idle(1);
    chk(bp_busy == 1'b0 && out_valid == 1'b0, "R1", "after release", int'({bp_busy, out_valid}), 0);

    // R10: fill with a message word, R11: write during fill is dropped
    bp_value = 16'h40A5; bp_start = 1'b1;
    @(negedge clk);
    bp_start = 1'b0;
    idle(5);
    hwrite(5, 16'h1234, 0);
    look(9); look(10);
    while (bp_busy) @(negedge clk);
    hread(5, 0);
    chk(host_rvalid && host_rdata == 16'h40A5, "R11", "word after fill", int'(host_rdata), 16'h40A5);
    look(100); look(2000);
    idle(3);

    // fixed words, loc=8M bp=32M
    loc_rate = 3'd2; bp_rate = 3'd4;
    hwrite(0, 16'h0764, 0);
    hwrite(1, 16'h932C, 0);
    hwrite(2, 16'h03C8, 0);
    hwrite(3, 16'h5F3C, 0);
    hwrite(4, 16'h2764, 0);
    hwrite(5, 16'h6055, 0);
    hwrite(6, 16'hC0EE, 0);
    hwrite(7, 16'h1F7F, 0);
    hwrite(8, 16'h821F, 0);
    hwrite(9, 16'h8220, 0);
    for (int i = 0; i < 10; i++) look(i);
    idle(3);

    // loc=32M (illegal), bp=2M
    loc_rate = 3'd4; bp_rate = 3'd0;
    idle(1);
    for (int i = 0; i < 10; i++) look(i);
    idle(3);
    // invalid rate codes
    loc_rate = 3'd6; bp_rate = 3'd7;
    idle(1);
    for (int i = 0; i < 10; i++) look(i);
    idle(3);
    loc_rate = 3'd3; bp_rate = 3'd1;
    idle(1);
    for (int i = 0; i < 10; i++) look(i);
    idle(3);

    // R3: access with a foreign select code
    hwrite(0, 16'hBEEF, 5);
    hread(0, 1);
    chk(host_rvalid == 1'b0, "R3", "foreign read valid", int'(host_rvalid), 0);
    hread(0, 0);
    chk(host_rvalid && host_rdata == 16'h0764, "R3", "word after foreign write", int'(host_rdata), 16'h0764);

    // R12: same-address write and lookup
    slot_req = 1'b1; slot_chan = 7;
    host_we = 1'b1; host_addr = 7; host_wdata = 16'h0A0B; host_sel = 3'b000;
    @(negedge clk);
    slot_req = 1'b0; host_we = 1'b0;
    chk(dm_rd_en && dm_stream == 5'd31 && dm_chan == 9'd127, "R12", "old word used",
        int'({dm_stream, dm_chan}), (31 << 9) | 127);
    look(7);
    chk(dm_rd_en && dm_stream == 5'd10 && dm_chan == 9'd11, "R12", "new word used",
        int'({dm_stream, dm_chan}), (10 << 9) | 11);
    idle(3);

    // mixed pseudo-random traffic, loc=16M bp=32M
    loc_rate = 3'd3; bp_rate = 3'd4;
    idle(1);
    seed = 32'h1ACE;
    for (int i = 0; i < 400; i++) begin
      seed = seed * 1103515245 + 12345;
      slot_req   = seed[16];
      slot_chan  = ADDR_W'((seed >>> 4) & 15);
      host_we    = seed[17];
      host_addr  = ADDR_W'((seed >>> 8) & 15);
      host_wdata = 16'(seed >>> 12);
      host_re    = seed[18] & ~seed[17];
      host_sel   = seed[19] ? 3'b001 : 3'b000;
      @(negedge clk);
    end
    slot_req = 1'b0; host_we = 1'b0; host_re = 1'b0; host_sel = 3'b000;
    idle(3);

    // second fill with lookups running during it
    bp_value = 16'h8123; bp_start = 1'b1;
    @(negedge clk);
    bp_start = 1'b0;
    for (int i = 0; i < 40; i++) look(i % 12);
    while (bp_busy) @(negedge clk);
    for (int i = 0; i < 12; i++) look(i);
    idle(4);

    summary();
    $finish;
  end
endmodule